// File: doc/BRIEF.md
# I2C Potentiometer Register Front End

This block is the serial slave interface that sits in front of the storage of a single-wiper digital potentiometer. It samples the two-wire bus lines with the system clock and cleans them up. It finds the start and stop framing, matches a fixed seven-bit device identifier and takes in an address byte and data bytes. It acknowledges by pulling its open-drain data line low, and it shifts read data out MSB first.

Toward the storage logic it raises single-cycle requests. A volatile wiper write fires when a data byte for register 0 completes. A non-volatile write fires on the STOP that closes such a write. A read strobe marks each read of register 0. The block keeps an access-control byte at register 2 itself. Bit 7 of that byte picks the route for register 0: when it is clear, writes also go to non-volatile storage and reads return the stored start-up value. When it is set, traffic reaches the live wiper only.

A write-protect input, active low, refuses data bytes. A busy input, held by the storage logic during power-up recall and non-volatile programming, makes the block deaf to the bus.

Top module: `i2c_pot_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe`=0), no request pulse is raised, and the access-control byte is 00h.
- R2: An identification byte whose upper seven bits are 0101000 is acknowledged, and its bit 0 selects read (1) or write (0). Any other identification byte is not acknowledged, and later bytes are ignored until the next START.
- R3: After a matching write-type identification byte, the next byte is taken as the register address and is acknowledged whatever its value.
- R4: A data byte written to address 0 is acknowledged. On the falling SCL edge after its LSB, the block raises a one-cycle `vol_we` with the byte on `wr_data`.
- R5: While `wp_n` is low, a data byte is neither acknowledged nor stored. No request is raised, and the slave goes idle until the next START.
- R6: A data byte written to address 2 is acknowledged and stored as the access-control byte. A read of address 2 returns it.
- R7: A STOP that closes a write to address 0 raises one `nv_we` pulse when access-control bit 7 was 0 at the write. When that bit is 1, no pulse follows.
- R8: A read is a write-type identification byte, an address byte, a repeated START and a read-type identification byte. For address 0 the block returns `init_q` when access-control bit 7 is 0 and `wiper_q` when it is 1. The byte goes out MSB first, with one `rd_req` pulse whose `rd_nv` is 1 in the first case and 0 in the second.
- R9: Addresses other than 0 and 2 are acknowledged. Write data to them raises no request, and reads of them return 00h.
- R10: While `busy` is high, START conditions are ignored, nothing is acknowledged and `sda_oe` stays 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_n | input | 1 | Write protect, low refuses data bytes |
| busy | input | 1 | Storage busy, high makes the block ignore the bus |
| wiper_q | input | 8 | Current live wiper value |
| init_q | input | 8 | Stored start-up wiper value |
| sda_oe | output | 1 | Pull the data line low when 1 |
| vol_we | output | 1 | One-cycle live wiper write request |
| nv_we | output | 1 | One-cycle non-volatile write request |
| rd_req | output | 1 | One-cycle read strobe for register 0 |
| rd_nv | output | 1 | With `rd_req`: 1 when the stored value was read |
| wr_data | output | 8 | Data for `vol_we` and `nv_we` |

## Verification
The bench runs full bus transactions at the pins. It reads register 0 under both access-control settings, and the two distinct storage values show which source was routed. It writes register 0 with bit 7 clear and set, which shows whether a non-volatile request follows the STOP. A write to register 2 followed by a read-back shows that the control byte is kept in the block. A wrong identifier, protected writes, an unmapped address and transfers while busy are each expected to produce no acknowledge or no request, so dropped and spurious responses both show up.

// File: rtl/i2c_pot_slave.sv
module i2c_pot_slave #(
  parameter int          FILT   = 3,
  parameter logic [6:0]  DEV_ID = 7'b0101000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_n,
  input  logic       busy,
  input  logic [7:0] wiper_q,
  input  logic [7:0] init_q,
  output logic       sda_oe,
  output logic       vol_we,
  output logic       nv_we,
  output logic       rd_req,
  output logic       rd_nv,
  output logic [7:0] wr_data
);

  localparam logic [7:0] A_POT = 8'd0;
  localparam logic [7:0] A_ACR = 8'd2;
  localparam logic [3:0] N_BITS = 4'd8;
  localparam logic [3:0] N_ACK  = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_WDAT, S_RDAT} st_t;

  logic [1:0]      scl_sy, sda_sy;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h  <= '1; sda_h  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_d  <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[FILT-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire start_c = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c  = scl_f & scl_d & ~sda_d & sda_f;
  wire rise    = scl_f & ~scl_d;
  wire fall    = ~scl_f & scl_d;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, addr, acr;
  logic       rw, nv_pend, mack;

  wire [7:0] rd_val = (addr == A_POT) ? (acr[7] ? wiper_q : init_q) :
                      (addr == A_ACR) ? acr : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; addr <= '0; acr <= '0;
      rw <= 1'b0; nv_pend <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; vol_we <= 1'b0; nv_we <= 1'b0;
      rd_req <= 1'b0; rd_nv <= 1'b0; wr_data <= '0;
    end else begin
      vol_we <= 1'b0;
      nv_we  <= 1'b0;
      rd_req <= 1'b0;
      if (busy) begin
        st <= S_IDLE; sda_oe <= 1'b0; nv_pend <= 1'b0; bitcnt <= '0;
      end else if (start_c) begin
        st <= S_ID; bitcnt <= '0; sda_oe <= 1'b0; nv_pend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; bitcnt <= '0;
        nv_we <= nv_pend; nv_pend <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bitcnt < N_BITS) begin
            if (st != S_RDAT) shreg <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (st == S_RDAT && bitcnt == N_ACK) begin
            mack <= ~sda_f;
          end
        end
        if (fall) begin
          if (st == S_RDAT) begin
            if (bitcnt == N_BITS) begin
              sda_oe <= 1'b0;
              bitcnt <= N_ACK;
            end else if (bitcnt == N_ACK) begin
              if (mack) begin
                shreg  <= rd_val;
                sda_oe <= ~rd_val[7];
                bitcnt <= '0;
                rd_req <= (addr == A_POT);
                rd_nv  <= ~acr[7];
              end else begin
                st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0;
              end
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end else if (bitcnt == N_BITS) begin
            bitcnt <= N_ACK;
            case (st)
              S_ID: begin
                if (shreg[7:1] == DEV_ID) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  st <= S_IDLE; bitcnt <= '0;
                end
              end
              S_ADDR: begin
                sda_oe <= 1'b1;
                addr   <= shreg;
              end
              S_WDAT: begin
                if (!wp_n) begin
                  st <= S_IDLE; bitcnt <= '0;
                end else begin
                  sda_oe <= 1'b1;
                  if (addr == A_POT) begin
                    vol_we  <= 1'b1;
                    wr_data <= shreg;
                    nv_pend <= ~acr[7];
                  end else if (addr == A_ACR) begin
                    acr <= shreg;
                  end
                end
              end
              default: ;
            endcase
          end else if (bitcnt == N_ACK) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ID: begin
                if (rw) begin
                  st     <= S_RDAT;
                  shreg  <= rd_val;
                  sda_oe <= ~rd_val[7];
                  rd_req <= (addr == A_POT);
                  rd_nv  <= ~acr[7];
                end else begin
                  st <= S_ADDR;
                end
              end
              S_ADDR:  st <= S_WDAT;
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_pot_slave_chk.sv
module i2c_pot_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wp_n,
  input logic sda_oe,
  input logic vol_we,
  input logic nv_we,
  input logic rd_req
);

  p_release_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !sda_oe);

  p_no_write_when_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we |-> $past(wp_n));

  p_single_wiper_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we |=> !vol_we);

  p_requests_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vol_we, nv_we, rd_req}));

  p_nv_not_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> !$past(busy));

  p_single_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

bind i2c_pot_slave i2c_pot_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wp_n(wp_n), .sda_oe(sda_oe),
  .vol_we(vol_we), .nv_we(nv_we), .rd_req(rd_req)
);

// File: tb/i2c_pot_slave_tb.sv
module i2c_pot_slave_tb;

  localparam int Q = 16;
  localparam logic [6:0] ID = 7'b0101000;
  localparam logic [7:0] WIPER = 8'hA5;
  localparam logic [7:0] INIT  = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp_n = 1'b1, busy = 1'b0;
  logic sda_oe, vol_we, nv_we, rd_req, rd_nv;
  logic [7:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;

  typedef struct { int kind; logic [7:0] val; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  i2c_pot_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_n(wp_n), .busy(busy), .wiper_q(WIPER), .init_q(INIT),
    .sda_oe(sda_oe), .vol_we(vol_we), .nv_we(nv_we),
    .rd_req(rd_req), .rd_nv(rd_nv), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [7:0] val, input string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && (vol_we || nv_we || rd_req)) begin
      int k;
      logic [7:0] v;
      string t;
      k = vol_we ? 0 : (nv_we ? 1 : 2);
      v = (k == 2) ? {7'd0, rd_nv} : wr_data;
      t = (k == 0) ? "R4" : ((k == 1) ? "R7" : "R8");
      if (q.size() == 0) begin
        check(1'b0, t, "unexpected request kind", k, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.kind == k, e.tag, "request kind", k, e.kind);
        check(e.val == v, e.tag, "request value", v, e.val);
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); end
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(!mack, s);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d,
                           output bit k1, output bit k2, output bit k3);
    bus_start();
    wr_byte({ID, 1'b0}, k1);
    wr_byte(a, k2);
    wr_byte(d, k3);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d,
                          output bit k1, output bit k2, output bit k3);
    bus_start();
    wr_byte({ID, 1'b0}, k1);
    wr_byte(a, k2);
    bus_start();
    wr_byte({ID, 1'b1}, k3);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit k1, k2, k3;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    check(vol_we == 1'b0, "R1", "vol_we after reset", vol_we, 0);
    check(nv_we == 1'b0,  "R1", "nv_we after reset", nv_we, 0);
    check(rd_req == 1'b0, "R1", "rd_req after reset", rd_req, 0);

    // R1/R8: default access byte 00h routes a read of 0 to the stored value
    push(2, 8'd1, "R8");
    read_reg(8'd0, d, k1, k2, k3);
    check(k1, "R2", "ack of write id", k1, 1);
    check(k2, "R3", "ack of address 0", k2, 1);
    check(k3, "R2", "ack of read id", k3, 1);
    check(d == INIT, "R8", "read 0 with access 00h", d, INIT);

    // R4/R7: write 0 with bit 7 clear -> live write, then stored write at STOP
    push(0, 8'h5A, "R4");
    push(1, 8'h5A, "R7");
    write_reg(8'd0, 8'h5A, k1, k2, k3);
    check(k3, "R4", "ack of data to address 0", k3, 1);

    // R6: set access byte to 80h and read it back
    write_reg(8'd2, 8'h80, k1, k2, k3);
    check(k3, "R6", "ack of data to address 2", k3, 1);
    read_reg(8'd2, d, k1, k2, k3);
    check(d == 8'h80, "R6", "read back access byte", d, 8'h80);

    // R7: bit 7 set -> live write only, no stored write
    push(0, 8'hC3, "R7");
    write_reg(8'd0, 8'hC3, k1, k2, k3);
    check(k3, "R4", "ack of data with access 80h", k3, 1);

    // R8: bit 7 set routes a read of 0 to the live wiper
    push(2, 8'd0, "R8");
    read_reg(8'd0, d, k1, k2, k3);
    check(d == WIPER, "R8", "read 0 with access 80h", d, WIPER);

    // R2: wrong identifier is not acked and later bytes are ignored
    bus_start();
    wr_byte({7'b0101001, 1'b0}, k1);
    wr_byte(8'h00, k2);
    bus_stop();
    check(!k1, "R2", "ack of wrong id", k1, 0);
    check(!k2, "R2", "ack after wrong id", k2, 0);

    // R5: write protect refuses the data byte and the next one
    wp_n = 1'b0;
    bus_start();
    wr_byte({ID, 1'b0}, k1);
    wr_byte(8'd0, k2);
    wr_byte(8'h11, k3);
    check(k2, "R3", "address ack under protect", k2, 1);
    check(!k3, "R5", "data ack under protect", k3, 0);
    wr_byte(8'h22, k3);
    check(!k3, "R5", "byte after refused data", k3, 0);
    bus_stop();
    wp_n = 1'b1;
    push(2, 8'd0, "R5");
    read_reg(8'd0, d, k1, k2, k3);
    check(d == WIPER, "R5", "wiper source unchanged after protect", d, WIPER);

    // R9: unmapped address
    write_reg(8'd5, 8'h77, k1, k2, k3);
    check(k2, "R9", "ack of address 5", k2, 1);
    check(k3, "R9", "ack of data to address 5", k3, 1);
    read_reg(8'd5, d, k1, k2, k3);
    check(d == 8'h00, "R9", "read of address 5", d, 0);

    // R10: busy hides the bus
    busy = 1'b1;
    bus_start();
    wr_byte({ID, 1'b0}, k1);
    wr_byte(8'd0, k2);
    check(!k1, "R10", "id ack while busy", k1, 0);
    check(!k2, "R10", "address ack while busy", k2, 0);
    check(sda_oe == 1'b0, "R10", "sda_oe while busy", sda_oe, 0);
    bus_stop();
    busy = 1'b0;
    wq();

    // R7: back to access 00h, stored write follows again
    write_reg(8'd2, 8'h00, k1, k2, k3);
    push(0, 8'h01, "R4");
    push(1, 8'h01, "R7");
    write_reg(8'd0, 8'h01, k1, k2, k3);
    check(k1 && k2 && k3, "R7", "acks of write after busy", {k1, k2, k3}, 7);

    repeat (50) @(negedge clk);
    check(q.size() == 0, (q.size() != 0) ? q[0].tag : "R4",
          "expected requests left over", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule